// File: doc/BRIEF.md
# Contrastive Weight Update Engine

This block applies the learning step of a mean-field Boltzmann learner to a table of symmetric connection weights. Once a pattern has been annealed twice, first with inputs and outputs clamped (teacher phase) and then with only the inputs clamped (student phase), the two final activation sets sit in a bank that no longer changes. The engine reads those two sets and walks the whole weight table. For every neuron pair (i, j) it forms the teacher coactivation and the student coactivation at full width and subtracts them. It divides the difference by a power of two, adds the result to the stored weight and writes the clamped sum back. The annealer can keep working on the next pattern from a different bank while the sweep runs.

Weights are stored once per unordered pair, in the upper triangle (column greater than row) of an N-by-N table. The external synchronous weight memory holds one word per (row, column group). Each word carries the weights of four adjacent columns, so the four update lanes handle one word per visit. A sequencer with four states steps through the words:
- IDLE: waits for `start`.
- FETCH: issues a read.
- APPLY: writes back the updated word.
- FINISH: raises `done` for one cycle and then returns to IDLE.

The transitions are: IDLE to FETCH on start; FETCH to APPLY always; APPLY back to FETCH while words remain; APPLY to FINISH after the last word; FINISH to IDLE always.

Top module: `cwu_engine`

## Requirements
- R1: A `start` pulse sampled in IDLE raises `busy` on the next cycle. The engine then visits every word once, in ascending address order, where address = row*(N/4) + column group. For the default of 16 neurons that gives rows 0..15, groups 0..3 and words 0..63.
- R2: Every visit is one read cycle (`mem_rd_en`) followed by the write cycle (`mem_wr_en`). The write goes to the address that was just read, using the data the memory returned one cycle after the read.
- R3: Lane k of word (row i, group c) handles column j = 4c + k. That lane's weight sits in word bits [5k+4:5k]. Its bit in `mem_wr_mask` is 1 only when j > i, so the diagonal and the lower triangle are never written.
- R4: The new weight is w + ((t_i*t_j - s_i*s_j) >>> lr_shift). The products are formed at full signed width, and the shift is arithmetic, so it rounds toward minus infinity. When the teacher and student products are equal, the weight is unchanged.
- R5: The written weight saturates at +15 and -16 (signed 5-bit) and never wraps.
- R6: `lr_shift` is captured when the sweep starts. Changing it during a sweep has no effect on that sweep.
- R7: A `start` pulse while `busy` is high is ignored. The running sweep still writes each word exactly once and produces exactly one `done`.
- R8: `done` is high for exactly one cycle, the cycle after the last write-back. `busy` is low on the following cycle.
- R9: While reset is asserted, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are low.
- R10: Activations are 5-bit two's-complement values. Neuron n sits in bits [5n+4:5n] of `teach_act` and `stud_act`, and both buses are held stable during a sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a sweep (one-cycle pulse) |
| lr_shift | input | 3 | Learning-rate right-shift amount |
| teach_act | input | 80 | Teacher-phase activations, 5 bits per neuron |
| stud_act | input | 80 | Student-phase activations, 5 bits per neuron |
| mem_rd_en | output | 1 | Weight memory read strobe |
| mem_rd_addr | output | 6 | Weight memory read word address |
| mem_rd_data | input | 20 | Weight word returned one cycle after the read |
| mem_wr_en | output | 1 | Weight memory write strobe |
| mem_wr_addr | output | 6 | Weight memory write word address |
| mem_wr_data | output | 20 | Updated weight word, 5 bits per lane |
| mem_wr_mask | output | 4 | Per-lane write enable (upper triangle only) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse after the last write-back |

## Verification
The first pattern uses identical teacher and student activations, so every product pair cancels and any stray change to a weight shows up. The second pattern uses unequal mixed-sign activations with a shift of 2, so the full-width subtraction and the flooring of odd negative differences can be told apart from truncation toward zero. The third pattern uses teacher activations at the extremes (-16 and +15) with zero student activations; this drives products of +256 and -240, which separates saturation from wrap-around in both directions. A final sweep changes `lr_shift` and pulses `start` partway through, which shows that the shift is latched and that a stray start neither restarts nor lengthens the sweep.

// File: rtl/cwu_pkg.sv
package cwu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_APPLY,
        ST_FINISH
    } cwu_state_e;
endpackage

// File: rtl/cwu_lane.sv
module cwu_lane #(
    parameter int W   = 5,
    parameter int SHW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] t_i,
    input  logic signed [W-1:0] t_j,
    input  logic signed [W-1:0] s_i,
    input  logic signed [W-1:0] s_j,
    input  logic signed [W-1:0] w_old,
    input  logic [SHW-1:0]      shift,
    output logic signed [W-1:0] w_new
);
    localparam int PW = 2 * W;
    localparam int DW = PW + 1;
    localparam int SW = DW + 1;
    localparam logic signed [SW-1:0] WMAX = SW'(2 ** (W - 1) - 1);
    localparam logic signed [SW-1:0] WMIN = SW'(-(2 ** (W - 1)));

    logic signed [PW-1:0] prod_t;
    logic signed [PW-1:0] prod_s;
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] scaled;
    logic signed [SW-1:0] sum;

    always_comb begin
        prod_t = PW'(t_i) * PW'(t_j);
        prod_s = PW'(s_i) * PW'(s_j);
        diff   = DW'(prod_t) - DW'(prod_s);
        scaled = diff >>> shift;
        sum    = SW'(scaled) + SW'(w_old);
        if (sum > WMAX)
            w_new = WMAX[W-1:0];
        else if (sum < WMIN)
            w_new = WMIN[W-1:0];
        else
            w_new = sum[W-1:0];
    end

    // R4
    no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_t == prod_s) |-> (w_new == w_old));
    // R5
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((SW'(w_old) == WMAX) && (prod_t >= prod_s)) |-> (SW'(w_new) == WMAX));
    // R5
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((SW'(w_old) == WMIN) && (prod_t <= prod_s)) |-> (SW'(w_new) == WMIN));
endmodule

// File: rtl/cwu_seq.sv
module cwu_seq
    import cwu_pkg::*;
#(
    parameter int N_NEU = 16,
    parameter int LANES = 4,
    parameter int SHW   = 3,
    parameter int GRPS  = N_NEU / LANES,
    parameter int RW    = $clog2(N_NEU),
    parameter int GW    = (GRPS > 1) ? $clog2(GRPS) : 1,
    parameter int WA    = $clog2(N_NEU * GRPS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [SHW-1:0] lr_shift,
    output logic [RW-1:0]  row,
    output logic [GW-1:0]  grp,
    output logic [SHW-1:0] shift_q,
    output logic [WA-1:0]  addr,
    output logic           rd_en,
    output logic           wr_en,
    output logic           busy,
    output logic           done
);
    cwu_state_e state, nxt;
    logic       last;

    assign last = (row == RW'(N_NEU - 1)) && (grp == GW'(GRPS - 1));
    assign addr = WA'(row) * WA'(GRPS) + WA'(grp);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_APPLY;
            ST_APPLY:  nxt = last ? ST_FINISH : ST_FETCH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row     <= '0;
            grp     <= '0;
            shift_q <= '0;
        end else if (state == ST_IDLE && start) begin
            row     <= '0;
            grp     <= '0;
            shift_q <= lr_shift;
        end else if (state == ST_APPLY && !last) begin
            if (grp == GW'(GRPS - 1)) begin
                grp <= '0;
                row <= row + 1'b1;
            end else begin
                grp <= grp + 1'b1;
            end
        end
    end

    always_comb begin
        rd_en = (state == ST_FETCH);
        wr_en = (state == ST_APPLY);
        done  = (state == ST_FINISH);
        busy  = (state != ST_IDLE);
    end

    // R1
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R2
    rd_wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(rd_en) && ($past(addr) == addr)));
    // R6
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(shift_q));
    // R8
    done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: rtl/cwu_engine.sv
module cwu_engine #(
    parameter int N_NEU = 16,
    parameter int LANES = 4,
    parameter int W     = 5,
    parameter int SHW   = 3,
    parameter int GRPS  = N_NEU / LANES,
    parameter int RW    = $clog2(N_NEU),
    parameter int GW    = (GRPS > 1) ? $clog2(GRPS) : 1,
    parameter int WA    = $clog2(N_NEU * GRPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SHW-1:0]     lr_shift,
    input  logic [N_NEU*W-1:0] teach_act,
    input  logic [N_NEU*W-1:0] stud_act,
    output logic               mem_rd_en,
    output logic [WA-1:0]      mem_rd_addr,
    input  logic [LANES*W-1:0] mem_rd_data,
    output logic               mem_wr_en,
    output logic [WA-1:0]      mem_wr_addr,
    output logic [LANES*W-1:0] mem_wr_data,
    output logic [LANES-1:0]   mem_wr_mask,
    output logic               busy,
    output logic               done
);
    logic [RW-1:0]  row;
    logic [GW-1:0]  grp;
    logic [SHW-1:0] shift_q;
    logic [WA-1:0]  addr;
    logic [LANES-1:0] lane_mask;

    cwu_seq #(.N_NEU(N_NEU), .LANES(LANES), .SHW(SHW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .lr_shift (lr_shift),
        .row      (row),
        .grp      (grp),
        .shift_q  (shift_q),
        .addr     (addr),
        .rd_en    (mem_rd_en),
        .wr_en    (mem_wr_en),
        .busy     (busy),
        .done     (done)
    );

    assign mem_rd_addr = addr;
    assign mem_wr_addr = addr;
    assign mem_wr_mask = mem_wr_en ? lane_mask : '0;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [RW-1:0] col;
        logic [W-1:0]  w_out;
        assign col          = RW'(int'(grp) * LANES + k);
        assign lane_mask[k] = (col > row);

        cwu_lane #(.W(W), .SHW(SHW)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .t_i   (teach_act[int'(row) * W +: W]),
            .t_j   (teach_act[int'(col) * W +: W]),
            .s_i   (stud_act[int'(row) * W +: W]),
            .s_j   (stud_act[int'(col) * W +: W]),
            .w_old (mem_rd_data[k * W +: W]),
            .shift (shift_q),
            .w_new (w_out)
        );
        assign mem_wr_data[k * W +: W] = w_out;
    end

    // R3
    lower_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && (mem_wr_addr >= WA'((N_NEU - 1) * GRPS))) |-> (mem_wr_mask == '0));
    // R3
    mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_en |-> (mem_wr_mask == '0));
endmodule

// File: tb/cwu_engine_bench.sv
module cwu_engine_bench;
    localparam int N = 16;
    localparam int L = 4;
    localparam int W = 5;
    localparam int G = N / L;
    localparam int WORDS = N * G;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [2:0] lr_shift = 0;
    logic [N*W-1:0] t_bus = '0;
    logic [N*W-1:0] s_bus = '0;
    logic mem_rd_en, mem_wr_en, busy, done;
    logic [5:0] mem_rd_addr, mem_wr_addr;
    logic [L*W-1:0] mem_rd_data, mem_wr_data;
    logic [L-1:0] mem_wr_mask;

    always #5 clk = ~clk;

    cwu_engine u_cwu_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .lr_shift(lr_shift),
        .teach_act(t_bus), .stud_act(s_bus),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_mask(mem_wr_mask), .busy(busy), .done(done)
    );

    // weight memory model with a load port owned by the bench
    logic [L*W-1:0] mem [WORDS];
    logic ld_en = 0;
    logic [5:0] ld_addr = 0;
    logic [L*W-1:0] ld_data = 0;

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (mem_wr_en)
            for (int k = 0; k < L; k++)
                if (mem_wr_mask[k]) mem[mem_wr_addr][k*W +: W] <= mem_wr_data[k*W +: W];
    end

    int n_chk = 0;
    int n_err = 0;
    int gw [N][N];
    int tact [N];
    int sact [N];
    int done_cnt = 0;
    int cyc = 0;

    typedef struct {
        logic [5:0]     addr;
        logic [L-1:0]   mask;
        logic [L*W-1:0] data;
    } exp_t;
    exp_t q [$];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int sx(input logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    function automatic int upd(input int w, input int ti, input int tj,
                               input int si, input int sj, input int sh);
        int d;
        d = ti * tj - si * sj;
        d = d >>> sh;
        w = w + d;
        if (w > 15) w = 15;
        if (w < -16) w = -16;
        return w;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // monitor: pops expected write-backs and compares
    logic prev_rd = 0;
    logic prev_wr = 0;
    logic [5:0] prev_rd_addr = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr_en) begin
                chk(prev_rd && prev_rd_addr == mem_wr_addr, "R2", int'(mem_wr_addr), int'(prev_rd_addr));
                if (q.size() == 0) begin
                    chk(0, "R1 extra write", int'(mem_wr_addr), -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(mem_wr_addr == e.addr, "R1 order", int'(mem_wr_addr), int'(e.addr));
                    chk(mem_wr_mask == e.mask, "R3 mask", int'(mem_wr_mask), int'(e.mask));
                    for (int k = 0; k < L; k++)
                        if (e.mask[k])
                            chk(mem_wr_data[k*W +: W] == e.data[k*W +: W], "R4/R5 lane",
                                sx(mem_wr_data[k*W +: W]), sx(e.data[k*W +: W]));
                end
            end
            if (done) begin
                done_cnt++;
                chk(prev_wr, "R8 done after last write", int'(prev_wr), 1);
            end
        end
        prev_rd      = mem_rd_en;
        prev_rd_addr = mem_rd_addr;
        prev_wr      = mem_wr_en;
    end

    task automatic seed(input int base);
        for (int a = 0; a < WORDS; a++) begin
            @(negedge clk);
            ld_en   = 1;
            ld_addr = 6'(a);
            for (int k = 0; k < L; k++) begin
                int v;
                v = ((a * 7 + k * 3 + base) % 32) - 16;
                ld_data[k*W +: W] = W'(v);
                gw[a / G][(a % G) * L + k] = v;
            end
        end
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic verify_mem();
        for (int a = 0; a < WORDS; a++)
            for (int k = 0; k < L; k++) begin
                int r, c, act;
                r = a / G;
                c = (a % G) * L + k;
                act = sx(mem[a][k*W +: W]);
                if (c > r) chk(act == gw[r][c], "R4 stored weight", act, gw[r][c]);
                else       chk(act == gw[r][c], "R3 untouched lower", act, gw[r][c]);
            end
    endtask

    // driver: computes expected write-backs and runs one sweep
    task automatic run_sweep(input int sh, input bit disturb);
        for (int n = 0; n < N; n++) begin
            t_bus[n*W +: W] = W'(tact[n]);
            s_bus[n*W +: W] = W'(sact[n]);
        end
        for (int r = 0; r < N; r++)
            for (int g = 0; g < G; g++) begin
                exp_t e;
                e.addr = 6'(r * G + g);
                e.mask = '0;
                e.data = '0;
                for (int k = 0; k < L; k++) begin
                    int c;
                    c = g * L + k;
                    if (c > r) begin
                        e.mask[k] = 1'b1;
                        gw[r][c] = upd(gw[r][c], tact[r], tact[c], sact[r], sact[c], sh);
                        e.data[k*W +: W] = W'(gw[r][c]);
                    end
                end
                q.push_back(e);
            end
        done_cnt = 0;
        @(negedge clk);
        lr_shift = 3'(sh);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        if (disturb) begin
            repeat (20) @(negedge clk);
            lr_shift = 3'(sh) ^ 3'd7;   // R6: change mid-sweep
            start = 1;                  // R7: stray start
            @(negedge clk);
            start = 0;
        end
        while (done_cnt == 0) @(negedge clk);
        chk(busy == 1'b0, "R8 busy low after done", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R7/R8 single done", done_cnt, 1);
        chk(q.size() == 0, "R1 all words written", q.size(), 0);
        chk(busy == 1'b0, "R7 no restart", int'(busy), 0);
        verify_mem();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9
        chk(busy == 0 && done == 0, "R9 busy/done in reset", int'({busy, done}), 0);
        chk(mem_rd_en == 0 && mem_wr_en == 0, "R9 strobes in reset", int'({mem_rd_en, mem_wr_en}), 0);
        rst_n = 1;
        seed(1);

        // R4 / R10: equal teacher and student, nothing may move
        for (int n = 0; n < N; n++) begin
            tact[n] = ((n * 5) % 32) - 16;
            sact[n] = tact[n];
        end
        run_sweep(0, 0);

        // R4: mixed signs, shift of 2 exercises flooring
        for (int n = 0; n < N; n++) begin
            tact[n] = ((n * 11 + 3) % 32) - 16;
            sact[n] = ((n * 7 + 9) % 32) - 16;
        end
        run_sweep(2, 0);

        // R5: extreme activations saturate both ways
        seed(5);
        for (int n = 0; n < N; n++) begin
            tact[n] = (n % 2 == 0) ? -16 : 15;
            sact[n] = 0;
        end
        run_sweep(0, 0);

        // R6 / R7: shift change and stray start mid-sweep
        seed(9);
        for (int n = 0; n < N; n++) begin
            tact[n] = ((n * 13 + 1) % 32) - 16;
            sact[n] = ((n * 3 + 20) % 32) - 16;
        end
        run_sweep(5, 1);

        // R4: largest shift
        run_sweep(7, 0);

        finish_run();
    end
endmodule